// File: doc/BRIEF.md
# Edge Interrupt and Wake Detector

This block watches a port of already synchronised pin levels and turns chosen transitions into interrupt and wakeup events. Each pin has two interrupt enables, one for rising transitions and one for falling transitions. When a pin changes in a direction whose enable is set, its bit in a pending vector is set. The pending bit stays set until software writes a one to that bit position through the clear selector. Any pending bit raises a single interrupt line towards the parent interrupt controller. Software reads the pending vector, services the lowest set bit, clears it, and reads the vector again until it is zero.

A second, independent pair of rising and falling enables selects the transitions that request a system wakeup. The wakeup flag can only be set while the sleep input is high. Once set, it holds until the sleep input drops. Only transitions are detected; a steady level never raises an event.

Configuration uses a simple write strobe with a 3-bit selector and a full-width data word. Each mask is always written as a whole word.

Top module: `edge_wake_det`

## Requirements
- R1: After reset, pend_o, irq_o and wake_o are all zero, and all four masks are zero. Pins that are already high when reset ends do not produce an edge, even after masks are enabled.
- R2: A write with cfg_we high replaces a whole mask word. cfg_sel 0 selects the rising interrupt mask, 1 the falling interrupt mask, 2 the rising wake mask and 3 the falling wake mask. The new mask applies from the next clock cycle. Writes with cfg_sel 5, 6 or 7 have no effect.
- R3: A low-to-high change of pin_lvl[i] with bit i of the rising interrupt mask set sets pend_o[i] at the next rising clock edge.
- R4: A high-to-low change of pin_lvl[i] with bit i of the falling interrupt mask set sets pend_o[i] at the next rising clock edge. A falling change on a pin with only its rising mask set leaves the bit clear.
- R5: With both interrupt masks set for a pin, either direction of change sets its pending bit. A pin held at a steady level never sets its pending bit again after it has been cleared.
- R6: A write with cfg_sel 4 clears every pending bit whose data bit is one. Pending bits whose data bit is zero are left unchanged.
- R7: If a clear and a new enabled edge hit the same bit in the same cycle, that pending bit stays set.
- R8: irq_o is high exactly when at least one pending bit is set.
- R9: The wake masks never set pending bits, and the interrupt masks never set wake_o.
- R10: wake_o is set by an edge enabled in a wake mask only while sleep_i is high. Once set, it stays set while sleep_i stays high.
- R11: wake_o returns to zero at the first rising clock edge at which sleep_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_lvl | input | NPINS | Synchronised pin levels |
| sleep_i | input | 1 | High while the system sleeps |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target of the write (0-3 masks, 4 clear) |
| cfg_wdata | input | NPINS | Write data word |
| pend_o | output | NPINS | Pending edge status vector |
| irq_o | output | 1 | OR of all pending bits |
| wake_o | output | 1 | Sticky wakeup request |

## Verification
Two functions can fall in the same cycle: a write-one clear of a pending bit and a new enabled transition on that same pin. The bench drives the pin change and the clear strobe on the same falling clock edge, so both reach the same rising edge. It then expects the bit to read set afterwards, because the new event must win over the clear. The same check also confirms that a clear of a bit with no new edge still takes effect on its own.

// File: rtl/ewd_pkg.sv
package ewd_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_RISE_IRQ  = 3'd0,
        SEL_FALL_IRQ  = 3'd1,
        SEL_RISE_WAKE = 3'd2,
        SEL_FALL_WAKE = 3'd3,
        SEL_CLEAR     = 3'd4
    } cfg_sel_e;
endpackage

// File: rtl/ewd_edge.sv
module ewd_edge #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic [NPINS-1:0] lvl,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    // The previous-level copy always follows the pins, also during reset,
    // so the first cycle after reset sees no change.
    always_comb begin
        st_d.prev = lvl;
        rise      = lvl & ~st_q.prev;
        fall      = ~lvl & st_q.prev;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/ewd_cfg.sv
module ewd_cfg
    import ewd_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] rise_irq_m,
    output logic [NPINS-1:0] fall_irq_m,
    output logic [NPINS-1:0] rise_wake_m,
    output logic [NPINS-1:0] fall_wake_m,
    output logic [NPINS-1:0] clr_vec
);
    typedef struct packed {
        logic [NPINS-1:0] rim;
        logic [NPINS-1:0] fim;
        logic [NPINS-1:0] rwm;
        logic [NPINS-1:0] fwm;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (we) begin
            case (sel)
                SEL_RISE_IRQ:  st_d.rim = wdata;
                SEL_FALL_IRQ:  st_d.fim = wdata;
                SEL_RISE_WAKE: st_d.rwm = wdata;
                SEL_FALL_WAKE: st_d.fwm = wdata;
                SEL_CLEAR:     clr_vec  = wdata;
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_irq_m  = st_q.rim;
    assign fall_irq_m  = st_q.fim;
    assign rise_wake_m = st_q.rwm;
    assign fall_wake_m = st_q.fwm;

    assert_rim_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_RISE_IRQ) |=> (rise_irq_m == $past(wdata)));

    assert_bad_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel > SEL_CLEAR) |=> ($stable(rise_irq_m) && $stable(fall_irq_m)
                                     && $stable(rise_wake_m) && $stable(fall_wake_m)));
endmodule

// File: rtl/ewd_pend.sv
module ewd_pend #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] rise,
    input  logic [NPINS-1:0] fall,
    input  logic [NPINS-1:0] rise_m,
    input  logic [NPINS-1:0] fall_m,
    input  logic [NPINS-1:0] clr_vec,
    output logic [NPINS-1:0] pend,
    output logic             irq
);
    typedef struct packed {
        logic [NPINS-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [NPINS-1:0] hit;

    // A new event takes priority over a clear of the same bit.
    always_comb begin
        hit       = (rise & rise_m) | (fall & fall_m);
        st_d.pend = (st_q.pend & ~clr_vec) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign irq  = |st_q.pend;

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr_vec[i]) |=> pend[i]);
        assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !rise[i] && !fall[i]) |=> !pend[i]);
        assert_race_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && rise[i] && rise_m[i]) |=> pend[i]);
        assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend[i] && !rise[i] && !fall[i]) |=> !pend[i]);
    end
endmodule

// File: rtl/ewd_wake.sv
module ewd_wake #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] rise,
    input  logic [NPINS-1:0] fall,
    input  logic [NPINS-1:0] rise_m,
    input  logic [NPINS-1:0] fall_m,
    input  logic             sleep,
    output logic             wake
);
    typedef struct packed {
        logic wake;
    } wake_st_t;

    wake_st_t st_d, st_q;
    logic     req;

    always_comb begin
        req       = |((rise & rise_m) | (fall & fall_m));
        st_d.wake = sleep && (st_q.wake || req);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake = st_q.wake;

    assert_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> !wake);
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && sleep) |=> wake);
    assert_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake && !req) |=> !wake);
endmodule

// File: rtl/edge_wake_det.sv
module edge_wake_det
    import ewd_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic             sleep_i,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [NPINS-1:0] cfg_wdata,
    output logic [NPINS-1:0] pend_o,
    output logic             irq_o,
    output logic             wake_o
);
    logic [NPINS-1:0] rise, fall;
    logic [NPINS-1:0] rim, fim, rwm, fwm, clr;

    ewd_edge #(.NPINS(NPINS)) u_edge (
        .clk (clk),
        .lvl (pin_lvl),
        .rise(rise),
        .fall(fall)
    );

    ewd_cfg #(.NPINS(NPINS)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .rise_irq_m (rim),
        .fall_irq_m (fim),
        .rise_wake_m(rwm),
        .fall_wake_m(fwm),
        .clr_vec    (clr)
    );

    ewd_pend #(.NPINS(NPINS)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise),
        .fall   (fall),
        .rise_m (rim),
        .fall_m (fim),
        .clr_vec(clr),
        .pend   (pend_o),
        .irq    (irq_o)
    );

    ewd_wake #(.NPINS(NPINS)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise),
        .fall  (fall),
        .rise_m(rwm),
        .fall_m(fwm),
        .sleep (sleep_i),
        .wake  (wake_o)
    );

    assert_irq_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (pend_o != '0));
    assert_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pin_lvl) && !cfg_we) |=> $stable(pend_o));
endmodule

// File: tb/edge_wake_det_tb_top.sv
module edge_wake_det_tb_top;
    localparam int NPINS = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NPINS-1:0] pin_lvl = 32'h0000_00F0;
    logic             sleep_i = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_sel = 3'd0;
    logic [NPINS-1:0] cfg_wdata = '0;
    logic [NPINS-1:0] pend_o;
    logic             irq_o, wake_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    edge_wake_det #(.NPINS(NPINS)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .sleep_i(sleep_i),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .pend_o(pend_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pins(input logic [31:0] v);
        pin_lvl = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 pend", pend_o, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        chk("R1 wake", {31'h0, wake_o}, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R1 no spurious edge", pend_o, 32'h0);
    endtask

    task automatic t_rise;
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h0000_0003);
        pins(32'h0000_00F3);
        chk("R3 rising sets", pend_o, 32'h0000_0003);
        chk("R8 irq high", {31'h0, irq_o}, 32'h1);
    endtask

    task automatic t_clear;
        wr(3'd4, 32'h0000_0001);
        chk("R6 clear one bit", pend_o, 32'h0000_0002);
        wr(3'd4, 32'h0);
        chk("R6 zero clears nothing", pend_o, 32'h0000_0002);
        wr(3'd4, 32'h0000_0002);
        chk("R6 clear last", pend_o, 32'h0);
        chk("R8 irq low", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_fall;
        wr(3'd1, 32'h0000_0010);
        pins(32'h0000_00E2);
        chk("R4 falling sets only masked", pend_o, 32'h0000_0010);
        wr(3'd4, 32'h0000_0010);
        repeat (3) @(negedge clk);
        chk("R5 steady level no event", pend_o, 32'h0);
    endtask

    task automatic t_both;
        wr(3'd0, 32'h0000_0100);
        wr(3'd1, 32'h0000_0100);
        pins(32'h0000_01E2);
        chk("R5 both masks rise", pend_o, 32'h0000_0100);
        wr(3'd4, 32'h0000_0100);
        pins(32'h0000_00E2);
        chk("R5 both masks fall", pend_o, 32'h0000_0100);
        wr(3'd4, 32'h0000_0100);
        chk("R5 cleared", pend_o, 32'h0);
    endtask

    task automatic t_race;
        pin_lvl = 32'h0000_01E2;
        wr(3'd4, 32'h0000_0100);
        chk("R7 edge beats clear", pend_o, 32'h0000_0100);
        wr(3'd4, 32'h0000_0100);
        chk("R7 later clear works", pend_o, 32'h0);
    endtask

    task automatic t_wake;
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h0000_1000);
        pins(32'h0000_11E2);
        chk("R10 no wake awake", {31'h0, wake_o}, 32'h0);
        chk("R9 wake mask no pend", pend_o, 32'h0);
        pins(32'h0000_01E2);
        sleep_i = 1'b1;
        pins(32'h0000_11E2);
        chk("R10 wake set in sleep", {31'h0, wake_o}, 32'h1);
        chk("R9 wake edge no pend", pend_o, 32'h0);
        pins(32'h0000_01E2);
        @(negedge clk);
        chk("R10 wake sticky", {31'h0, wake_o}, 32'h1);
        sleep_i = 1'b0;
        @(negedge clk);
        chk("R11 wake drops", {31'h0, wake_o}, 32'h0);
        sleep_i = 1'b1;
        wr(3'd0, 32'h0000_2000);
        pins(32'h0000_21E2);
        chk("R9 irq mask no wake", {31'h0, wake_o}, 32'h0);
        chk("R9 irq mask pend", pend_o, 32'h0000_2000);
        wr(3'd4, 32'h0000_2000);
        wr(3'd3, 32'h0000_4000);
        pins(32'h0000_61E2);
        chk("R9 fall wake ignores rise", {31'h0, wake_o}, 32'h0);
        pins(32'h0000_21E2);
        chk("R10 falling wake", {31'h0, wake_o}, 32'h1);
        sleep_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_badsel;
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        pins(32'h0000_01E3);
        chk("R2 bad select ignored", pend_o, 32'h0);
        sleep_i = 1'b1;
        pins(32'h0000_01E2);
        chk("R2 bad select no wake", {31'h0, wake_o}, 32'h0);
        sleep_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_clear();
        t_fall();
        t_both();
        t_race();
        t_wake();
        t_badsel();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule